// File: doc/BRIEF.md
# Look-Ahead Pipelined Binary Up-Counter

This block is a free-running synchronous up-counter whose output is plain binary and whose clock period stays the same as it gets wider. The count is split into a low stage `LOW_W` bits wide and a chain of two-bit upper pairs. The low stage advances on every edge. Each upper pair advances only on an edge where every bit below it is one. That condition is never computed from the live count. It is assembled from registered pieces that were prepared in earlier cycles, so each pair's increment decision is at most a three-input AND on every edge.

Two kinds of registered signal drive each pair. A look-ahead chain starts from an early equality decode of the low stage and is delayed so that it is true exactly in the cycle where the low stage holds all ones. A carry register, one per pair, records in the previous cycle that all lower pairs were at three. Every pair and every register switches on the same rising edge. The block has no load, no direction control and no terminal-count pin. Its only inputs are a clock and a synchronous reset, and it exposes the count bits, which are valid in every cycle.

The width must equal `LOW_W + 2*P` for some number of pairs P between 1 and `2**LOW_W - 1`. This gives at most 8 bits for a 2-bit low stage, 17 bits for a 3-bit low stage and 34 bits for a 4-bit low stage. Any other combination stops elaboration.

Top module: `la_pipe_counter`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `count` to zero, and `count` stays zero for as long as `rst` is held.
- R2: Each rising edge with `rst` low adds one to `count` modulo 2^W. The new value is visible in the same cycle, so the first edge after reset is released gives 1.
- R3: From all ones, a single edge returns `count` to zero, and the next edge gives 1 with no stall.
- R4: The low `LOW_W` bits step through 0 to 2^LOW_W-1 on every edge, whatever the upper bits hold.
- R5: Upper pair k (k counted from 1) occupies bits `LOW_W+2k-2` and `LOW_W+2k-1`. It changes only on an edge where all bits below it were one before that edge, and it then advances by one modulo 4.
- R6: A carry reaches every pair on the same edge where the low stage wraps. This includes the first carry after reset and carries that reach the top pair.
- R7: Counting from reset, after 40 edges `count` reads binary 101000. The following seven edges read 41 through 47, ending at 101111.
- R8: A reset applied while a carry is pending (low stage at all ones) clears the pending look-ahead state. After release, the first carry into pair 1 falls on the fourth edge for `LOW_W` = 2, and later carries fall on their normal edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every register in the block |
| rst | input | 1 | Synchronous reset, active high; clears the count and all look-ahead and carry registers |
| count | output | W | Current count in plain binary |

## Verification
The hardest overlap is a reset on the same edge where a carry would otherwise take effect. This happens when the low stage is at all ones and the look-ahead chains and carry registers are already primed. The bench raises `rst` with the count at 255 on the 8-bit instance and at 3. It then requires zero on that edge and a correct count across the next carries, which it judges against an edge counter kept in the bench. The second overlap is a wrap of the whole count together with the low-stage wrap. A sweep of more than two full wraps of both instances judges this, with every edge compared and every upper pair required to hold still unless the bits below it were all ones.

// File: rtl/la_cnt_pkg.sv
package la_cnt_pkg;

  // Widest count reachable with a given low-stage width: one pair per
  // early-decode slot of the low stage.
  function automatic int la_max_width(input int low_w);
    return low_w + 2 * ((1 << low_w) - 1);
  endfunction

  function automatic int la_pair_count(input int w, input int low_w);
    return (w - low_w) / 2;
  endfunction

endpackage

// File: rtl/la_low_stage.sv
module la_low_stage #(
  parameter int LOW_W = 3,
  parameter int PAIRS = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LOW_W-1:0] q,
  output logic [PAIRS:1]   early
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q + LOW_W'(1);
  end

  // Slot k fires k cycles before the low stage reaches all ones.
  for (genvar k = 1; k <= PAIRS; k++) begin : g_dec
    localparam logic [LOW_W-1:0] HIT = LOW_W'((2 ** LOW_W - 1) - k);
    assign early[k] = (q == HIT);
  end

  p_low_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (rst || q == LOW_W'($past(q) + 1)))
    else $error("R4: low stage did not advance by one");

endmodule

// File: rtl/la_delay_chain.sv
module la_delay_chain #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] sr;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-2:0], d};
    end
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/la_pair_stage.sv
module la_pair_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       carry_in,
  input  logic       look,
  output logic [1:0] q,
  output logic       path,
  output logic       carry_out
);

  // Counting-path register: one-cycle-early copy of "all lower pairs at 3".
  always_ff @(posedge clk) begin
    if (rst) path <= 1'b0;
    else     path <= carry_in;
  end

  always_ff @(posedge clk) begin
    if (rst)               q <= 2'd0;
    else if (path && look) q <= q + 2'd1;
  end

  assign carry_out = path & q[1] & q[0];

endmodule

// File: rtl/la_pipe_counter.sv
module la_pipe_counter
  import la_cnt_pkg::*;
#(
  parameter int W     = 17,
  parameter int LOW_W = 3
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);

  localparam int PAIRS = la_pair_count(W, LOW_W);
  localparam int MAX_W = la_max_width(LOW_W);

  if (LOW_W < 2 || W <= LOW_W || ((W - LOW_W) % 2) != 0 || W > MAX_W) begin : g_bad
    $error("la_pipe_counter: W and LOW_W do not form a supported combination");
  end

  logic [LOW_W-1:0] low_q;
  logic [PAIRS:1]   early;
  logic [PAIRS:1]   look;
  logic [PAIRS:1]   path;
  logic [PAIRS:0]   carry;

  assign carry[0] = 1'b1;

  la_low_stage #(.LOW_W(LOW_W), .PAIRS(PAIRS)) u_low (
    .clk   (clk),
    .rst   (rst),
    .q     (low_q),
    .early (early)
  );

  assign count[LOW_W-1:0] = low_q;

  for (genvar k = 1; k <= PAIRS; k++) begin : g_pair
    localparam int LO = LOW_W + 2 * k - 2;
    logic [1:0] pq;

    la_delay_chain #(.DEPTH(k)) u_look (
      .clk (clk),
      .rst (rst),
      .d   (early[k]),
      .q   (look[k])
    );

    la_pair_stage u_stage (
      .clk       (clk),
      .rst       (rst),
      .carry_in  (carry[k-1]),
      .look      (look[k]),
      .q         (pq),
      .path      (path[k]),
      .carry_out (carry[k])
    );

    assign count[LO+1:LO] = pq;

    // R5: a pair moves only after all lower bits were ones
    p_pair_gate_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && count[LO+1:LO] != $past(count[LO+1:LO])) |->
        $past(&count[LO-1:0]))
      else $error("R5: pair %0d moved without a full carry", k);

    // R6: delayed early decode lines up with the low-stage wrap cycle
    p_look_align_r6: assert property (@(posedge clk) disable iff (rst)
      look[k] == (&low_q))
      else $error("R6: look-ahead for pair %0d misaligned", k);

    if (k >= 2) begin : g_path_chk
      p_path_match_r6: assert property (@(posedge clk) disable iff (rst)
        look[k] |-> (path[k] == (&count[LO-1:LOW_W])))
        else $error("R6: carry register of pair %0d stale", k);
    end else begin : g_path_first
      p_path_first_r6: assert property (@(posedge clk) disable iff (rst)
        look[k] |-> path[k])
        else $error("R6: first carry register not set");
    end
  end

  p_clear_r1: assert property (@(posedge clk)
    rst |=> (count == '0))
    else $error("R1: count not cleared by reset");

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (rst || count == W'($past(count) + 1)))
    else $error("R2: count did not advance by one");

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (&count) |=> (rst || count == '0))
    else $error("R3: all-ones did not wrap to zero");

  p_top_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (carry[PAIRS] && look[PAIRS]) |-> (&count))
    else $error("R3: top carry without all-ones count");

endmodule

// File: tb/tb_la_pipe_counter.sv
module tb_la_pipe_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cnt8;
  logic [10:0] cnt11;

  always #2 clk = ~clk;

  la_pipe_counter #(.W(8), .LOW_W(2)) dut (
    .clk (clk), .rst (rst), .count (cnt8)
  );

  la_pipe_counter #(.W(11), .LOW_W(3)) dut_w (
    .clk (clk), .rst (rst), .count (cnt11)
  );

  int nchk = 0;
  int nfail = 0;
  int n = 0;

  localparam int NV = 12;
  localparam int VCYC [NV] = '{0, 1, 3, 4, 5, 16, 40, 41, 44, 47, 255, 256};
  localparam int VEXP [NV] = '{0, 1, 3, 4, 5, 16, 'h28, 'h29, 'h2C, 'h2F, 'hFF, 0};

  function automatic string vtag(input int i);
    case (i)
      0:              return "R1";
      1, 2, 10:       return "R2";
      3, 5:           return "R6";
      4:              return "R4";
      6, 7, 8, 9:     return "R7";
      default:        return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d (edge %0d)", tag, got, exp, n);
    end
  endtask

  // One edge; the bench's own edge counter models the count.
  task automatic step();
    @(posedge clk);
    if (rst) n = 0;
    else     n++;
    @(negedge clk);
  endtask

  task automatic do_reset(input int edges);
    rst = 1'b1;
    repeat (edges) step();
    check("R1", int'(cnt8), 0);
    check("R1", int'(cnt11), 0);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic run_to(input int target);
    while (n < target) step();
  endtask

  initial begin
    #80000;
    nfail++;
    $display("FAIL R2: watchdog expired at edge %0d", n);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] prev8;
    @(negedge clk);
    do_reset(3);

    // Table walk on the 8-bit instance
    for (int i = 0; i < NV; i++) begin
      run_to(VCYC[i]);
      check(vtag(i), int'(cnt8), VEXP[i]);
    end

    // Sweep over more than two wraps of both instances
    do_reset(2);
    prev8 = cnt8;
    for (int i = 0; i < 4200; i++) begin
      step();
      check((n % 256 == 0) ? "R3" : ((n % 4 == 0) ? "R6" : "R2"), int'(cnt8), n % 256);
      check((n % 2048 == 0) ? "R3" : "R2", int'(cnt11), n % 2048);
      check("R4", int'(cnt8[1:0]), n % 4);
      if (prev8[1:0] != 2'b11)
        check("R5", int'(cnt8[7:2]), int'(prev8[7:2]));
      prev8 = cnt8;
    end

    // Reset on the edge where a full wrap is pending
    do_reset(2);
    run_to(255);
    check("R3", int'(cnt8), 255);
    rst = 1'b1;
    step();
    check("R8", int'(cnt8), 0);
    check("R8", int'(cnt11), 0);
    step();
    check("R1", int'(cnt8), 0);
    rst = 1'b0;
    n = 0;
    run_to(3);
    check("R8", int'(cnt8), 3);
    step();
    check("R8", int'(cnt8), 4);
    run_to(16);
    check("R8", int'(cnt8), 16);
    run_to(64);
    check("R8", int'(cnt8), 64);
    check("R8", int'(cnt11), 64);

    // Reset while the low stage sits at all ones
    do_reset(1);
    run_to(3);
    rst = 1'b1;
    step();
    rst = 1'b0;
    n = 0;
    check("R8", int'(cnt8), 0);
    run_to(4);
    check("R8", int'(cnt8), 4);
    check("R8", int'(cnt11), 4);
    run_to(8);
    check("R8", int'(cnt8), 8);
    check("R8", int'(cnt11), 8);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule